// File: doc/BRIEF.md
# 8-bit ALU With Carry Chaining

A purely combinational arithmetic and logic unit for an 8-bit datapath. It takes an operation code, a first operand A, a second operand that is either a register value or an immediate constant, and the carry flag stored by the previous operation. It returns the 8-bit result together with updated carry, zero, negative and two's-complement overflow flags. There is no clock inside the block. The surrounding pipeline registers the outputs and feeds the stored carry back in.

Add-with-carry, subtract-with-borrow and the rotates use the incoming carry. A plain add or subtract on the low bytes, followed by the carry-consuming form on the higher bytes, therefore builds 16-bit or wider arithmetic. Logic operations leave the stored carry alone, so a mask or clear can sit between two chained steps. Increment, decrement and nibble swap also leave it alone.

Top module: `alu8`

## Requirements
- R1: `op_i` encoding: 0 ADD, 1 ADC, 2 SUB, 3 SBC, 4 INC, 5 DEC, 6 AND, 7 OR, 8 XOR, 9 COM, 10 NEG, 11 LSL, 12 LSR, 13 ROL, 14 ROR, 15 ASR, 16 SWAP. The second operand B is `imm_i` when `imm_sel_i`=1, else `b_i`.
- R2: ADD gives A+B and ADC gives A+B+`carry_i`. The result is the low 8 bits and `carry_o` is the carry out of bit 7, so 0x34+0xCD followed by ADC 0x12+0xAB gives 0xBE01.
- R3: SUB gives A-B and SBC gives A-B-`carry_i`. `carry_o` is 1 when a borrow occurs (A < B, or A < B+`carry_i` for SBC), so 0x01-0x34 followed by SBC 0xBE-0x12 gives 0xABCD.
- R4: For ADD, ADC, SUB and SBC, `ovf_o` is 1 exactly when the signed result of the operation lies outside -128..127.
- R5: INC gives A+1 and DEC gives A-1, modulo 256. `carry_o` equals `carry_i`. `ovf_o` is 1 only for INC of 0x7F and DEC of 0x80.
- R6: AND, OR and XOR apply bitwise to A and B. `carry_o` equals `carry_i` and `ovf_o`=0. XOR of equal operands gives 0x00 with `zero_o`=1.
- R7: COM gives ~A, with `carry_o`=1 and `ovf_o`=0.
- R8: NEG gives 0-A modulo 256, so 5 becomes 0xFB. `carry_o` is 1 unless A=0, and `ovf_o` is 1 only for A=0x80.
- R9: LSL shifts left with 0 into bit 0 and bit 7 into `carry_o`. LSR shifts right with 0 into bit 7 and bit 0 into `carry_o`.
- R10: ROL shifts left with `carry_i` into bit 0 and bit 7 into `carry_o`. ROR shifts right with `carry_i` into bit 7 and bit 0 into `carry_o`.
- R11: ASR shifts right, keeps bit 7 unchanged and moves bit 0 into `carry_o`.
- R12: SWAP exchanges bits 7:4 with bits 3:0, with `carry_o` equal to `carry_i` and `ovf_o`=0.
- R13: For every operation, `zero_o` is 1 exactly when `res_o`=0x00 and `neg_o` equals `res_o` bit 7. For the five shift codes, `ovf_o` equals `neg_o` XOR `carry_o`.
- R14: Codes 17 to 31 pass A to `res_o`, with `carry_o` equal to `carry_i` and `ovf_o`=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| op_i | input | 5 | Operation code (R1) |
| a_i | input | 8 | Operand A, also the destination value |
| b_i | input | 8 | Register operand B |
| imm_i | input | 8 | Immediate operand B |
| imm_sel_i | input | 1 | 1 selects `imm_i` as B |
| carry_i | input | 1 | Stored carry from the previous operation |
| res_o | output | 8 | Result |
| carry_o | output | 1 | Updated carry |
| zero_o | output | 1 | Result is zero |
| neg_o | output | 1 | Result bit 7 |
| ovf_o | output | 1 | Two's-complement overflow |

## Verification
The block holds no state, so any wrong operand steering, carry-in choice or flag select appears at the ports in the same evaluation as the stimulus. A wrong carry policy is the most damaging error. Examples are a carry that is forced where it should be held, or a borrow left uninverted. Such an error may still give a correct result byte, but it corrupts the upper byte of a chained operation one step later. For that reason the bench feeds the observed carry into the next operation and checks whole 16-bit values as well as each individual vector.

// File: rtl/alu8_pkg.sv
package alu8_pkg;
  localparam int unsigned OP_W = 5;

  typedef enum logic [OP_W-1:0] {
    OP_ADD  = 5'd0,
    OP_ADC  = 5'd1,
    OP_SUB  = 5'd2,
    OP_SBC  = 5'd3,
    OP_INC  = 5'd4,
    OP_DEC  = 5'd5,
    OP_AND  = 5'd6,
    OP_OR   = 5'd7,
    OP_XOR  = 5'd8,
    OP_COM  = 5'd9,
    OP_NEG  = 5'd10,
    OP_LSL  = 5'd11,
    OP_LSR  = 5'd12,
    OP_ROL  = 5'd13,
    OP_ROR  = 5'd14,
    OP_ASR  = 5'd15,
    OP_SWAP = 5'd16
  } alu_op_e;
endpackage

// File: rtl/alu8_arith.sv
module alu8_arith
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              ovf_o,
  output logic              hit_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic [DATA_W-1:0] x, y;
  logic              ci, inv, keep_c;
  logic [DATA_W:0]   sum;

  // every arithmetic op maps onto one adder: x + y + ci
  always_comb begin
    x      = a_i;
    y      = b_i;
    ci     = 1'b0;
    inv    = 1'b0;
    keep_c = 1'b0;
    hit_o  = 1'b1;
    case (op_i)
      OP_ADD: ci = 1'b0;
      OP_ADC: ci = carry_i;
      OP_SUB: begin y = ~b_i; ci = 1'b1;     inv = 1'b1; end
      OP_SBC: begin y = ~b_i; ci = ~carry_i; inv = 1'b1; end
      OP_INC: begin y = '0;   ci = 1'b1;     keep_c = 1'b1; end
      OP_DEC: begin y = '1;   ci = 1'b0;     keep_c = 1'b1; end
      OP_NEG: begin x = '0;   y = ~a_i; ci = 1'b1; inv = 1'b1; end
      default: hit_o = 1'b0;
    endcase
  end

  assign sum     = {1'b0, x} + {1'b0, y} + {{DATA_W{1'b0}}, ci};
  assign res_o   = sum[MSB:0];
  // borrow is the inverted adder carry for subtract-type ops
  assign carry_o = keep_c ? carry_i : (sum[DATA_W] ^ inv);
  assign ovf_o   = (x[MSB] == y[MSB]) && (sum[MSB] != x[MSB]);
endmodule

// File: rtl/alu8_logic.sv
module alu8_logic
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              hit_o
);
  localparam int unsigned HALF = DATA_W / 2;

  always_comb begin
    res_o   = a_i;
    carry_o = carry_i;
    hit_o   = 1'b1;
    case (op_i)
      OP_AND:  res_o = a_i & b_i;
      OP_OR:   res_o = a_i | b_i;
      OP_XOR:  res_o = a_i ^ b_i;
      OP_COM:  begin res_o = ~a_i; carry_o = 1'b1; end
      OP_SWAP: res_o = {a_i[HALF-1:0], a_i[DATA_W-1:HALF]};
      default: hit_o = 1'b0;
    endcase
  end
endmodule

// File: rtl/alu8_shift.sv
module alu8_shift
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  alu_op_e           op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              hit_o
);
  localparam int unsigned MSB = DATA_W - 1;

  logic fill, left;

  always_comb begin
    fill  = 1'b0;
    left  = 1'b0;
    hit_o = 1'b1;
    case (op_i)
      OP_LSL: begin left = 1'b1; fill = 1'b0; end
      OP_ROL: begin left = 1'b1; fill = carry_i; end
      OP_LSR: fill = 1'b0;
      OP_ROR: fill = carry_i;
      OP_ASR: fill = a_i[MSB];
      default: hit_o = 1'b0;
    endcase
  end

  assign res_o   = left ? {a_i[MSB-1:0], fill} : {fill, a_i[MSB:1]};
  assign carry_o = left ? a_i[MSB] : a_i[0];
endmodule

// File: rtl/alu8.sv
module alu8
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input  logic [OP_W-1:0]   op_i,
  input  logic [DATA_W-1:0] a_i,
  input  logic [DATA_W-1:0] b_i,
  input  logic [DATA_W-1:0] imm_i,
  input  logic              imm_sel_i,
  input  logic              carry_i,
  output logic [DATA_W-1:0] res_o,
  output logic              carry_o,
  output logic              zero_o,
  output logic              neg_o,
  output logic              ovf_o
);
  localparam int unsigned MSB = DATA_W - 1;

  alu_op_e           op;
  logic [DATA_W-1:0] b_eff;
  logic [DATA_W-1:0] ar_res, lg_res, sh_res;
  logic              ar_c, ar_v, ar_hit;
  logic              lg_c, lg_hit;
  logic              sh_c, sh_hit;

  assign op    = alu_op_e'(op_i);
  assign b_eff = imm_sel_i ? imm_i : b_i;

  alu8_arith #(.DATA_W(DATA_W)) u_arith (
    .op_i(op), .a_i(a_i), .b_i(b_eff), .carry_i(carry_i),
    .res_o(ar_res), .carry_o(ar_c), .ovf_o(ar_v), .hit_o(ar_hit)
  );

  alu8_logic #(.DATA_W(DATA_W)) u_logic (
    .op_i(op), .a_i(a_i), .b_i(b_eff), .carry_i(carry_i),
    .res_o(lg_res), .carry_o(lg_c), .hit_o(lg_hit)
  );

  alu8_shift #(.DATA_W(DATA_W)) u_shift (
    .op_i(op), .a_i(a_i), .carry_i(carry_i),
    .res_o(sh_res), .carry_o(sh_c), .hit_o(sh_hit)
  );

  always_comb begin
    res_o   = a_i;
    carry_o = carry_i;
    ovf_o   = 1'b0;
    if (ar_hit) begin
      res_o   = ar_res;
      carry_o = ar_c;
      ovf_o   = ar_v;
    end else if (lg_hit) begin
      res_o   = lg_res;
      carry_o = lg_c;
    end else if (sh_hit) begin
      res_o   = sh_res;
      carry_o = sh_c;
      ovf_o   = sh_res[MSB] ^ sh_c;
    end
  end

  assign zero_o = ~|res_o;
  assign neg_o  = res_o[MSB];
endmodule

// File: rtl/alu8_chk.sv
module alu8_chk
  import alu8_pkg::*;
#(
  parameter int unsigned DATA_W = 8
) (
  input logic [OP_W-1:0]   op_i,
  input logic [DATA_W-1:0] a_i,
  input logic [DATA_W-1:0] b_i,
  input logic [DATA_W-1:0] imm_i,
  input logic              imm_sel_i,
  input logic              carry_i,
  input logic [DATA_W-1:0] res_o,
  input logic              carry_o,
  input logic              zero_o,
  input logic              neg_o,
  input logic              ovf_o
);
  localparam int unsigned MSB  = DATA_W - 1;
  localparam int unsigned HALF = DATA_W / 2;

  logic [DATA_W-1:0] bo;
  logic [DATA_W:0]   wide;

  always_comb begin
    bo   = imm_sel_i ? imm_i : b_i;
    wide = {1'b0, a_i} + {1'b0, bo};
    if (op_i == OP_ADD)
      p_add_sum_r2: assert ({carry_o, res_o} == wide) else $error("r2 add");
    if (op_i == OP_SUB)
      p_sub_borrow_r3: assert (carry_o == (a_i < bo) && res_o == a_i - bo) else $error("r3 sub");
    // R5 R12: carry held by inc, dec, bitwise ops and swap
    if (op_i == OP_AND || op_i == OP_OR || op_i == OP_XOR || op_i == OP_SWAP ||
        op_i == OP_INC || op_i == OP_DEC)
      p_carry_hold_r6: assert (carry_o == carry_i) else $error("r6 carry hold");
    if (op_i == OP_XOR && a_i == bo)
      p_xor_self_r6: assert (zero_o && res_o == '0) else $error("r6 xor self");
    if (op_i == OP_COM)
      p_com_r7: assert (res_o == ~a_i && carry_o && !ovf_o) else $error("r7 com");
    if (op_i == OP_NEG)
      p_neg_carry_r8: assert (carry_o == (a_i != '0)) else $error("r8 neg");
    if (op_i == OP_ASR)
      p_asr_sign_r11: assert (res_o[MSB] == a_i[MSB] && neg_o == a_i[MSB] && carry_o == a_i[0])
        else $error("r11 asr");
    if (op_i == OP_SWAP)
      p_swap_r12: assert (res_o == {a_i[HALF-1:0], a_i[MSB:HALF]}) else $error("r12 swap");
    if (op_i > OP_SWAP)
      p_rsvd_pass_r14: assert (res_o == a_i && carry_o == carry_i && !ovf_o) else $error("r14 rsvd");
  end
endmodule

bind alu8 alu8_chk #(.DATA_W(DATA_W)) u_chk (
  .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .imm_sel_i(imm_sel_i),
  .carry_i(carry_i), .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o),
  .neg_o(neg_o), .ovf_o(ovf_o)
);

// File: tb/alu8_bench.sv
`timescale 1ns/1ps
module alu8_bench;
  logic       clk = 1'b0;
  logic [4:0] op_i = '0;
  logic [7:0] a_i = '0, b_i = '0, imm_i = '0;
  logic       imm_sel_i = 1'b0, carry_i = 1'b0;
  logic [7:0] res_o;
  logic       carry_o, zero_o, neg_o, ovf_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #2.5 clk = ~clk;

  alu8 u_alu8 (
    .op_i(op_i), .a_i(a_i), .b_i(b_i), .imm_i(imm_i), .imm_sel_i(imm_sel_i),
    .carry_i(carry_i), .res_o(res_o), .carry_o(carry_o), .zero_o(zero_o),
    .neg_o(neg_o), .ovf_o(ovf_o)
  );

  function automatic int sx(int v);
    return (v > 127) ? v - 256 : v;
  endfunction

  // returns {res[7:0], c, z, n, v}
  function automatic logic [11:0] model(int op, int a, int b, int ci);
    int r, s;
    bit c, v, shf;
    r = a; c = ci[0]; v = 0; shf = 0;
    case (op)
      0:  begin r = a + b;      c = (r > 255); s = sx(a) + sx(b);      v = (s > 127 || s < -128); end
      1:  begin r = a + b + ci; c = (r > 255); s = sx(a) + sx(b) + ci; v = (s > 127 || s < -128); end
      2:  begin r = a - b;      c = (a < b);      s = sx(a) - sx(b);      v = (s > 127 || s < -128); end
      3:  begin r = a - b - ci; c = (a < b + ci); s = sx(a) - sx(b) - ci; v = (s > 127 || s < -128); end
      4:  begin r = a + 1; v = (a == 127); end
      5:  begin r = a - 1; v = (a == 128); end
      6:  r = a & b;
      7:  r = a | b;
      8:  r = a ^ b;
      9:  begin r = 255 - a; c = 1; end
      10: begin r = 256 - a; c = (a != 0); v = (a == 128); end
      11: begin r = a * 2;                 c = (a >= 128);   shf = 1; end
      12: begin r = a / 2;                 c = a[0];         shf = 1; end
      13: begin r = a * 2 + ci;            c = (a >= 128);   shf = 1; end
      14: begin r = a / 2 + ci * 128;      c = a[0];         shf = 1; end
      15: begin r = a / 2 + (a & 128);     c = a[0];         shf = 1; end
      16: r = (a % 16) * 16 + a / 16;
      default: r = a;
    endcase
    r = r & 255;
    if (shf) v = r[7] ^ c;
    return {r[7:0], c, (r == 0), r[7], v};
  endfunction

  function automatic string tag_of(int op);
    case (op)
      0, 1:    return "R2";
      2, 3:    return "R3";
      4, 5:    return "R5";
      6, 7, 8: return "R6";
      9:       return "R7";
      10:      return "R8";
      11, 12:  return "R9";
      13, 14:  return "R10";
      15:      return "R11";
      16:      return "R12";
      default: return "R14";
    endcase
  endfunction

  task automatic check_val(string tag, logic [15:0] got, logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  // drive at negedge, sample 1 ns later; full vector vs model (R13 flags included)
  task automatic apply(int op, int a, int b, int imm, bit sel, bit ci, string tag);
    logic [11:0] exp;
    int bsel;
    @(negedge clk);
    op_i = op[4:0]; a_i = a[7:0]; b_i = b[7:0]; imm_i = imm[7:0];
    imm_sel_i = sel; carry_i = ci;
    #1;
    bsel = sel ? imm : b;
    exp = model(op, a & 255, bsel & 255, ci);
    checks++;
    if ({res_o, carry_o, zero_o, neg_o, ovf_o} !== exp) begin
      fails++;
      $display("FAIL %s/R13 op=%0d a=%h b=%h ci=%b: got %h expected %h",
               tag, op, a_i, bsel[7:0], ci, {res_o, carry_o, zero_o, neg_o, ovf_o}, exp);
    end
  endtask

  initial begin
    logic [7:0] lo;
    #1;
    check_val("R13 idle zero flag", {15'd0, zero_o}, 16'd1);

    // R1 immediate select: register b ignored
    apply(6, 8'h55, 8'hFF, 8'h0F, 1'b1, 1'b0, "R1");
    check_val("R1 imm and", {8'h0, res_o}, 16'h0005);
    apply(7, 8'h00, 8'h00, 8'h0F, 1'b1, 1'b1, "R1");

    // R2 16-bit add chain
    apply(0, 8'h34, 8'hCD, 0, 1'b0, 1'b0, "R2");
    lo = res_o;
    apply(1, 8'h12, 8'hAB, 0, 1'b0, carry_o, "R2");
    check_val("R2 chain sum", {res_o, lo}, 16'hBE01);

    // R3 16-bit subtract chain
    apply(2, 8'h01, 8'h34, 0, 1'b0, 1'b0, "R3");
    lo = res_o;
    apply(3, 8'hBE, 8'h12, 0, 1'b0, carry_o, "R3");
    check_val("R3 chain diff", {res_o, lo}, 16'hABCD);
    apply(3, 8'h00, 8'h00, 0, 1'b0, 1'b1, "R3");

    // R4 overflow corners
    apply(0, 8'h7F, 8'h01, 0, 1'b0, 1'b0, "R4");
    check_val("R4 add ovf", {15'd0, ovf_o}, 16'd1);
    apply(2, 8'h80, 8'h01, 0, 1'b0, 1'b0, "R4");
    apply(1, 8'h7F, 8'h00, 0, 1'b0, 1'b1, "R4");

    // R5
    apply(4, 8'h7F, 0, 0, 1'b0, 1'b0, "R5");
    apply(4, 8'hFF, 0, 0, 1'b0, 1'b1, "R5");
    apply(5, 8'h80, 0, 0, 1'b0, 1'b1, "R5");
    apply(5, 8'h00, 0, 0, 1'b0, 1'b0, "R5");

    // R6 xor self clears, carry kept
    apply(8, 8'hA5, 8'hA5, 0, 1'b0, 1'b1, "R6");
    check_val("R6 xor clear", {res_o, 7'd0, carry_o}, 16'h0001);

    // R7 / R8
    apply(9, 8'h55, 0, 0, 1'b0, 1'b0, "R7");
    apply(10, 8'h05, 0, 0, 1'b0, 1'b0, "R8");
    check_val("R8 neg 5", {8'h0, res_o}, 16'h00FB);
    apply(10, 8'h00, 0, 0, 1'b0, 1'b1, "R8");
    apply(10, 8'h80, 0, 0, 1'b0, 1'b0, "R8");

    // R9 / R10 shift then rotate through carry
    apply(11, 8'hAA, 0, 0, 1'b0, 1'b0, "R9");
    apply(13, 8'hAA, 0, 0, 1'b0, carry_o, "R10");
    check_val("R10 rol carry in", {8'h0, res_o}, 16'h0055);
    apply(12, 8'hAA, 0, 0, 1'b0, 1'b1, "R9");
    apply(14, 8'hAA, 0, 0, 1'b0, 1'b1, "R10");

    // R11 / R12 / R14
    apply(15, 8'h81, 0, 0, 1'b0, 1'b0, "R11");
    apply(16, 8'h0F, 0, 0, 1'b0, 1'b1, "R12");
    check_val("R12 swap", {8'h0, res_o}, 16'h00F0);
    apply(17, 8'h3C, 8'h11, 0, 1'b0, 1'b1, "R14");
    apply(31, 8'h00, 8'hFF, 0, 1'b0, 1'b0, "R14");

    void'($urandom(32'd7331));
    for (int i = 0; i < 3000; i++) begin
      int op;
      op = $urandom % 32;
      apply(op, $urandom % 256, $urandom % 256, $urandom % 256,
            1'($urandom % 2), 1'($urandom % 2), tag_of(op));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule